// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Registers

This block keeps a running calendar in packed BCD: century, year, month, date, day of week, hours, minutes and seconds. A one-cycle `tick_1hz` pulse moves the internal counters forward by one second. Month lengths are handled automatically, and so is the leap day. Software never touches the counters directly. It reads and writes a bank of shadow bytes, and every time the counters advance, all of those bytes are refreshed together from the new count.

Two control bits decide how the shadow bank and the counters interact:
- The freeze bit stops refreshes, so a multi-byte read sees one coherent instant.
- The set bit also stops refreshes. When software clears it, the whole shadow bank, century included, is committed into the counters.

A stop bit in the seconds byte gates the tick. The bus is a simple synchronous byte port. Writes take effect on the clock edge, and reads are combinational from the registers.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59 and hours from 00 to 23. Each rolls over to 00 and carries into the next field.
- R2: Day of week counts 1 to 7. It advances when hours roll over and wraps from 7 to 1, regardless of the date.
- R3: The date wraps after the last day of the month: 31, 30, or 28/29 for month 02. Every year whose BCD value is divisible by 4 (including 00) is a leap year. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00 and increments the century.
- R4: The bus address map is as follows:
  - Address 0 is control. Bit 7 is the set bit, bit 6 is the freeze bit, and the other bits read 0.
  - Addresses 1 to 7 hold seconds, minutes, hours, day of week, date, month and year, in that order.
  - Address 8 holds the century.
  - Addresses 9 to 15 read 0, and writes to them change nothing.
  - Read data is valid in the same cycle as the address.
- R5: While the freeze bit is 1, ticks do not change the shadow bytes. A tick in the same cycle as the write that sets the freeze bit still completes its refresh.
- R6: After the freeze bit is cleared, the shadow bytes keep their old values until the next counting tick. That tick loads them with the counter value, which has kept running during the freeze.
- R7: While the set bit is 1, ticks do not refresh the shadow bytes. A control write that clears the set bit copies all eight shadow time bytes into the counters. The next tick then shows the loaded time plus one second.
- R8: Bit 7 of the seconds byte is the stop bit, and it reads back in that position.
  - While it is 1, ticks neither count nor refresh.
  - It can be written without the set bit.
  - After it is cleared, the next tick counts.
- R9: After reset, control reads 00 and the stop bit is 0. The time reads century 20, year 00, month 01, date 01, day 01 and 00:00:00.
- R10: A write to a time byte while the set bit is 0 changes only the shadow copy. The next refresh replaces it with the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Write strobe for the byte port |
| bus_addr | input | ADDR_W | Byte address (0 control, 1-7 time, 8 century) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed byte |

## Verification
A table of start times pushes the counters across the difficult boundaries:
- February in leap and common years, including year 00.
- 30-day and 31-day month ends.
- The year and century wrap.
- The day-of-week wrap on its own.

A design that tested leap years wrongly, or that tied day of week to the date, would return a wrong date or weekday after a single tick.

Directed sequences check the freeze and set paths:
- A tick that coincides with the freeze write must still refresh. A design that let the halt win would show a stale second.
- After the freeze is cleared, the bench requires the stale value to persist until the next tick. A design that refreshed at once would fail that check.

A stop bit that failed to gate the tick, or that needed the set bit before it could be written, would show a changed seconds count after the stopped ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dat;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mi;
    logic [7:0] se;
  } cal_time_t;

  // add one to a packed BCD byte (no range limit)
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  // last day of the month, in BCD
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // one second forward, full calendar cascade
  function automatic cal_time_t cal_advance(input cal_time_t t);
    cal_time_t r;
    r = t;
    if (t.se != 8'h59) r.se = bcd_step(t.se);
    else begin
      r.se = 8'h00;
      if (t.mi != 8'h59) r.mi = bcd_step(t.mi);
      else begin
        r.mi = 8'h00;
        if (t.hr != 8'h23) r.hr = bcd_step(t.hr);
        else begin
          r.hr  = 8'h00;
          r.dow = (t.dow == 8'h07) ? 8'h01 : bcd_step(t.dow);
          if (t.dat != month_last(t.mon, t.yr)) r.dat = bcd_step(t.dat);
          else begin
            r.dat = 8'h01;
            if (t.mon != 8'h12) r.mon = bcd_step(t.mon);
            else begin
              r.mon = 8'h01;
              if (t.yr != 8'h99) r.yr = bcd_step(t.yr);
              else begin
                r.yr  = 8'h00;
                r.cen = (t.cen == 8'h99) ? 8'h00 : bcd_step(t.cen);
              end
            end
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter logic [63:0] RST_TIME = 64'h2000_0101_0100_0000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      load_en,
  input  cal_time_t load_val,
  output cal_time_t cnt_o,
  output cal_time_t nxt_o,
  output logic      adv_o
);

  cal_time_t cnt_q;

  // a commit takes priority over a tick in the same cycle
  assign adv_o = tick_en && !load_en;
  assign nxt_o = cal_advance(cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= cal_time_t'(RST_TIME);
    else if (load_en) cnt_q <= load_val;
    else if (adv_o)   cnt_q <= nxt_o;
  end

endmodule

// File: rtl/cal_regbank.sv
module cal_regbank #(
  parameter int          ADDR_W   = 4,
  parameter int          NBYTES   = 8,
  parameter logic [63:0] RST_TIME = 64'h2000_0101_0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [8*NBYTES-1:0] nxt_i,
  input  logic              adv_i,
  output logic [8*NBYTES-1:0] shd_o,
  output logic              load_o,
  output logic              stop_o,
  output logic              halt_o,
  output logic              refresh_o
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = '0;
  localparam int                TOP_ADDR = NBYTES;

  logic                set_q, frz_q, stop_q;
  logic [8*NBYTES-1:0] shd_q;
  logic                ctl_wr;

  assign ctl_wr    = bus_we && (bus_addr == CTL_ADDR);
  assign load_o    = ctl_wr && set_q && !bus_wdata[7];
  assign halt_o    = set_q || frz_q;
  assign refresh_o = adv_i && !halt_o;
  assign stop_o    = stop_q;
  assign shd_o     = shd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q  <= 1'b0;
      frz_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        set_q <= bus_wdata[7];
        frz_q <= bus_wdata[6];
      end
      if (bus_we && (bus_addr == ADDR_W'(1))) stop_q <= bus_wdata[7];
    end
  end

  // one register per shadow byte; the refresh wins over a bus write
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(g + 1);
    logic [7:0] wval;
    assign wval = (g == 0) ? {1'b0, bus_wdata[6:0]} : bus_wdata;
    always_ff @(posedge clk) begin
      if (!rst_n)                             shd_q[g*8 +: 8] <= RST_TIME[g*8 +: 8];
      else if (refresh_o)                     shd_q[g*8 +: 8] <= nxt_i[g*8 +: 8];
      else if (bus_we && (bus_addr == BADDR)) shd_q[g*8 +: 8] <= wval;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == CTL_ADDR) begin
      bus_rdata = {set_q, frz_q, 6'b0};
    end else if (int'(bus_addr) <= TOP_ADDR) begin
      bus_rdata = shd_q[(int'(bus_addr) - 1) * 8 +: 8];
      if (bus_addr == ADDR_W'(1)) bus_rdata[7] = stop_q;
    end
  end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [63:0] RST_TIME = 64'h2000_0101_0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam int NBYTES = $bits(cal_time_t) / 8;

  // named internal events, observed by the bound checker
  cal_time_t           cnt, nxt;
  logic [8*NBYTES-1:0] shd;
  logic                adv, load, stop, halted, refresh, tick_en;

  assign tick_en = tick_1hz && !stop;

  cal_counter #(.RST_TIME(RST_TIME)) counter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (load),
    .load_val (cal_time_t'(shd)),
    .cnt_o    (cnt),
    .nxt_o    (nxt),
    .adv_o    (adv)
  );

  cal_regbank #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .RST_TIME(RST_TIME)) regbank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .nxt_i     (nxt),
    .adv_i     (adv),
    .shd_o     (shd),
    .load_o    (load),
    .stop_o    (stop),
    .halt_o    (halted),
    .refresh_o (refresh)
  );

endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      bus_we,
  input cal_time_t cnt,
  input logic [63:0] shd,
  input logic      adv,
  input logic      load,
  input logic      stop,
  input logic      halted,
  input logic      refresh
);

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt.se == 8'h59) |=> (cnt.se == 8'h00)); // R1

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt.dow == 8'h07 && cnt.hr == 8'h23 && cnt.mi == 8'h59 && cnt.se == 8'h59)
      |=> (cnt.dow == 8'h01)); // R2

  AST_YEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt.mon == 8'h12 && cnt.dat == 8'h31 && cnt.hr == 8'h23 && cnt.mi == 8'h59 && cnt.se == 8'h59)
      |=> (cnt.mon == 8'h01 && cnt.dat == 8'h01)); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !bus_we) |=> $stable(shd)); // R5

  AST_REFRESH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (shd == cnt)); // R6

  AST_LOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(shd))); // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(cnt)); // R8

endmodule

bind bcd_calendar_clock cal_checker checker_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_we  (bus_we),
  .cnt     (cnt),
  .shd     (shd),
  .adv     (adv),
  .load    (load),
  .stop    (stop),
  .halted  (halted),
  .refresh (refresh)
);

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {start, expected after one tick}; bytes: cen yr mon date dow hr min sec
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h2024_0228_0323_5959, 64'h2024_0229_0400_0000},
    {64'h2023_0228_0723_5959, 64'h2023_0301_0100_0000},
    {64'h2099_1231_0523_5959, 64'h2100_0101_0600_0000},
    {64'h2000_0430_0223_5959, 64'h2000_0501_0300_0000},
    {64'h2000_0131_0112_5959, 64'h2000_0131_0113_0000},
    {64'h2000_0229_0123_5959, 64'h2000_0301_0200_0000},
    {64'h2000_0731_0623_5959, 64'h2000_0801_0700_0000},
    {64'h2012_0228_0409_0909, 64'h2012_0228_0409_0910},
    {64'h2021_1130_0323_5959, 64'h2021_1201_0400_0000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_calendar_clock dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic expect_time(input string tag, input logic [63:0] t);
    logic [7:0] d;
    for (int a = 1; a <= 8; a++) begin
      rd(4'(a), d);
      check($sformatf("%s addr %0d", tag, a), d, t[(a - 1) * 8 +: 8]);
    end
  endtask

  task automatic load_time(input logic [63:0] t);
    wr(4'd0, 8'h80);
    for (int a = 1; a <= 8; a++) wr(4'(a), t[(a - 1) * 8 +: 8]);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog got timeout exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(4'd0, d); check("R9 control", d, 8'h00);
    expect_time("R9 reset time", 64'h2000_0101_0100_0000);

    // R4 unmapped address reads 0, write ignored
    wr(4'd9, 8'h55);
    rd(4'd9, d); check("R4 unmapped read", d, 8'h00);
    expect_time("R4 after unmapped write", 64'h2000_0101_0100_0000);
    wr(4'd0, 8'h3F);
    rd(4'd0, d); check("R4 control low bits", d, 8'h00);

    // R1 R2 R3 R7 vector table: commit a start time, one tick, compare
    for (int i = 0; i < NVEC; i++) begin
      load_time(VEC[i][127:64]);
      expect_time($sformatf("R7 loaded vec %0d", i), VEC[i][127:64]);
      tick();
      expect_time($sformatf("R1/R2/R3 vec %0d", i), VEC[i][63:0]);
    end

    // R7 set bit blocks refresh, commit then next tick
    wr(4'd0, 8'h80);
    for (int a = 1; a <= 8; a++) wr(4'(a), 64'h2000_0101_0110_0030 >> ((a - 1) * 8));
    tick();
    rd(4'd1, d); check("R7 set halts refresh", d, 8'h30);
    rd(4'd0, d); check("R4 control set bit", d, 8'h80);
    wr(4'd0, 8'h00);
    rd(4'd1, d); check("R7 no refresh on commit", d, 8'h30);
    tick();
    rd(4'd1, d); check("R7 commit plus one", d, 8'h31);
    rd(4'd3, d); check("R7 hours committed", d, 8'h10);

    // R5 R6 freeze (counter at 10:00:31)
    wr(4'd0, 8'h40);
    rd(4'd0, d); check("R4 control freeze bit", d, 8'h40);
    tick();
    rd(4'd1, d); check("R5 freeze holds", d, 8'h31);
    wr(4'd0, 8'h00);
    rd(4'd1, d); check("R6 stale after unfreeze", d, 8'h31);
    tick();
    rd(4'd1, d); check("R6 refresh with running count", d, 8'h33);

    // R5 tick in same cycle as freeze write still refreshes
    @(negedge clk);
    tick_1hz = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h40;
    @(negedge clk);
    tick_1hz = 1'b0; bus_we = 1'b0;
    rd(4'd1, d); check("R5 refresh in progress completes", d, 8'h34);
    tick();
    rd(4'd1, d); check("R5 held after halt", d, 8'h34);
    wr(4'd0, 8'h00);

    // R8 R10 stop bit (counter at 10:00:35)
    wr(4'd1, 8'h80);
    rd(4'd1, d); check("R8 stop bit visible", d, 8'h80);
    tick(); tick();
    rd(4'd1, d); check("R8 stopped no change", d, 8'h80);
    wr(4'd1, 8'h00);
    rd(4'd1, d); check("R10 shadow write seen", d, 8'h00);
    tick();
    rd(4'd1, d); check("R8/R10 count resumes", d, 8'h36);
    rd(4'd2, d); check("R10 minutes", d, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule